// File: doc/BRIEF.md
# Four-Channel Timer with Capture/Compare Channel and Interrupt Masking

This block is a 16-bit free-running timer that advances on a divided clock tick, with four channels watching it. Channels one to three only compare. Channel four either compares or captures, selected by a mode bit. Software reaches the block through a small word-wide register port. That port holds a control register, a sticky event-flag register, an interrupt-enable register, a read-only view of the counter, and the four channel value registers.

Three interrupt request lines leave the block. One is shared by the three compare-only channels. One belongs to channel four. One signals counter wrap. Each line is a plain AND of a flag with its enable bit, ORed where lines are shared. Setting the stop bit freezes the counter and the divider and forces both to zero, so that a later release restarts counting from a known point.

Top module: `tmr_chan_ctrl`

## Requirements
- R1: While control bit 0 (stop) is 1, the counter and the divider are held at zero. After the write that clears stop, the counter reads floor(n/d) after n further clock edges, where d is the division factor.
- R2: Control bits 3:2 select the division factor d: 00 gives 1, 01 gives 4, 10 gives 8, 11 gives 16.
- R3: Channel k (k = 1..3) sets flag bit 8-k (bit 7 for channel one, bit 6 for two, bit 5 for three) on the tick where the counter equals its value register. After a release with value C, the flag first reads 1 after (C+1)*d edges.
- R4: Flag bit 3 sets on the tick where the counter wraps from 0xFFFF to 0x0000.
- R5: Control bit 1 chooses channel four's function: 1 is capture only, 0 is compare only. In the unselected function, neither flag bit 4 nor the channel-four register is changed.
- R6: In capture mode, a capture input that was low and is raised before edge e is sampled through two synchronizer flops. At edge e+2 the register takes the counter value of the cycle before e+2, and flag bit 4 sets.
- R7: Writing the flag register clears each flag whose data bit is 1 and leaves flags with a 0 data bit unchanged. A set event in the same cycle wins over the clear.
- R8: The enable register and the flag register reset to 0x00. Enable bits 7:3 match the flag bit positions, and bits 2:0 always read 0.
- R9: irq_cmp is high exactly when some compare-only channel has both its flag and its enable bit set.
- R10: irq_ch4 is high when flag bit 4 and enable bit 4 are both set. irq_ovf is high when flag bit 3 and enable bit 3 are both set. The meaning of enable bit 4 follows the mode in R5.
- R11: The register map is: address 0 control, 1 flags, 2 enables, 3 counter (read only), 4 to 7 channel one to four value. The control register resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for write and read |
| wdata | input | 16 | Write data |
| rd_data | output | 16 | Combinational read data for addr |
| cap_in | input | 1 | Asynchronous capture input for channel four |
| irq_cmp | output | 1 | Shared compare request for channels one to three |
| irq_ch4 | output | 1 | Channel-four request (capture or compare) |
| irq_ovf | output | 1 | Counter wrap request |

## Verification
The bench sweeps every division factor against each compare-only channel. It checks the flag one edge before and exactly at (C+1)*d edges. A divider that counted one tick too many or too few, or a compare against the incremented count, would move the flag by a whole tick. A clear write is timed to land on the very edge of a match. A design that let the clear win would lose that event. Capture is checked for the exact latched value two synchronizer edges after the input rises, and channel four is checked for ignoring the other function in each mode. A full 65536-tick run confirms that the wrap flag appears on the wrapping edge and not on the edge before it.

// File: rtl/tmr_pkg.sv
// Package: shared constants and types of the four-channel timer.
// Assumes a fixed register map of eight word addresses.
package tmr_pkg;
    localparam int CH_NUM   = 4;                 // last channel is capture-capable
    localparam int FLAG_W   = 8;
    localparam int ADDR_W   = 3;
    localparam int SEL_W    = 2;
    localparam int PRE_W    = 4;                 // holds the largest divide-1 (15)
    localparam int OVF_BIT  = 3;

    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_FLAG = 3'd1;
    localparam logic [ADDR_W-1:0] A_MASK = 3'd2;
    localparam logic [ADDR_W-1:0] A_CNT  = 3'd3;
    localparam int                A_CH0  = 4;

    // Flag/enable bits that exist: channels at 7..4, wrap at 3.
    localparam logic [FLAG_W-1:0] FLAG_USED = 8'hF8;

    typedef struct packed {
        logic [SEL_W-1:0] psel;      // divide select
        logic             cap_mode;  // channel four: 1 capture, 0 compare
        logic             stop;      // hold counter and divider at zero
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    // Flag bit position of channel i (0-based).
    function automatic int ch_bit(input int i);
        return FLAG_W - 1 - i;
    endfunction
endpackage

// File: rtl/tmr_prescale.sv
// Divider: emits a one-cycle tick every d clocks, with d = 1, 4, 8 or 16
// chosen by sel. Held at zero while stop is high, so counting restarts in phase.
module tmr_prescale #(
    parameter int SEL_W = 2,
    parameter int PRE_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stop,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] limit;

    // Last count value of the divide cycle for the selected factor.
    always_comb begin
        if (sel == '0) limit = '0;
        else           limit = PRE_W'((1 << (int'(sel) + 1)) - 1);
    end

    // Tick on the last count; >= keeps a shortened select from stalling.
    assign tick = !stop && (pre_q >= limit);

    // Divider count register.
    always_ff @(posedge clk) begin
        if (!rst_n || stop) pre_q <= '0;
        else if (tick)      pre_q <= '0;
        else                pre_q <= pre_q + 1'b1;
    end
endmodule

// File: rtl/tmr_counter.sv
// Main up-counter: advances once per tick and is held at zero while stopped.
// wrap flags the tick on which the all-ones value rolls over.
module tmr_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         stop,
    input  logic         tick,
    output logic [W-1:0] cnt,
    output logic         wrap
);
    logic [W-1:0] cnt_q;

    // Counter register.
    always_ff @(posedge clk) begin
        if (!rst_n || stop) cnt_q <= '0;
        else if (tick)      cnt_q <= cnt_q + 1'b1;
    end

    assign cnt  = cnt_q;
    assign wrap = tick && (&cnt_q);
endmodule

// File: rtl/tmr_cap_sync.sv
// Capture input conditioner: STAGES flops against metastability, plus one
// flop for edge detection. rise is high for one cycle per low-to-high change.
module tmr_cap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic [STAGES:0] sh_q;

    // Synchronizer and edge-history shift register.
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-1:0], din};
    end

    assign rise = sh_q[STAGES-1] && !sh_q[STAGES];
endmodule

// File: rtl/tmr_chan.sv
// One timer channel: a value register that software writes and a capture
// event loads (capture wins), plus a comparator that reports a match on a tick.
// Assumes cmp_en and cap_take are never used together by the parent.
module tmr_chan #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         tick,
    input  logic [W-1:0] cnt,
    input  logic         cmp_en,
    input  logic         cap_take,
    output logic [W-1:0] value,
    output logic         hit
);
    logic [W-1:0] val_q;

    // Value register: capture, then software write.
    always_ff @(posedge clk) begin
        if (!rst_n)        val_q <= '0;
        else if (cap_take) val_q <= cnt;
        else if (wr)       val_q <= wdata;
    end

    assign value = val_q;
    assign hit   = cmp_en && tick && (cnt == val_q);
endmodule

// File: rtl/tmr_chan_ctrl.sv
// Four-channel timer top: register port, divider, counter, channels, sticky
// flags, enables and the three request lines. Reads are combinational.
// Assumes cap_in may be asynchronous; every other input is synchronous to clk.
module tmr_chan_ctrl
    import tmr_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  rd_data,
    input  logic              cap_in,
    output logic              irq_cmp,
    output logic              irq_ch4,
    output logic              irq_ovf
);
    localparam int LAST = CH_NUM - 1;

    ctrl_t             ctrl_q;
    logic [FLAG_W-1:0] flags_q;
    logic [FLAG_W-1:0] mask_q;
    logic [FLAG_W-1:0] flag_set;
    logic [FLAG_W-1:0] flag_clr;
    logic              tick;
    logic [CNT_W-1:0]  cnt_q;
    logic              wrap;
    logic              cap_rise;
    logic [CNT_W-1:0]  ch_val  [CH_NUM];
    logic [CH_NUM-1:0] ch_hit;
    logic [CH_NUM-1:0] ch_cap;

    // Control register.
    always_ff @(posedge clk) begin
        if (!rst_n)                         ctrl_q <= '0;
        else if (wr_en && addr == A_CTRL)   ctrl_q <= ctrl_t'(wdata[CTRL_W-1:0]);
    end

    // Enable register; bits without a source stay zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                         mask_q <= '0;
        else if (wr_en && addr == A_MASK)   mask_q <= wdata[FLAG_W-1:0] & FLAG_USED;
    end

    tmr_prescale #(.SEL_W(SEL_W), .PRE_W(PRE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .stop  (ctrl_q.stop),
        .sel   (ctrl_q.psel),
        .tick  (tick)
    );

    tmr_counter #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .stop  (ctrl_q.stop),
        .tick  (tick),
        .cnt   (cnt_q),
        .wrap  (wrap)
    );

    tmr_cap_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (cap_in),
        .rise  (cap_rise)
    );

    // Channels: the last one is mode-switched, the others only compare.
    for (genvar i = 0; i < CH_NUM; i++) begin : g_ch
        logic cmp_en_i;
        if (i == LAST) begin : g_dual
            assign cmp_en_i  = !ctrl_q.cap_mode;
            assign ch_cap[i] = ctrl_q.cap_mode && cap_rise;
        end else begin : g_cmp
            assign cmp_en_i  = 1'b1;
            assign ch_cap[i] = 1'b0;
        end

        tmr_chan #(.W(CNT_W)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr       (wr_en && (addr == ADDR_W'(A_CH0 + i))),
            .wdata    (wdata),
            .tick     (tick),
            .cnt      (cnt_q),
            .cmp_en   (cmp_en_i),
            .cap_take (ch_cap[i]),
            .value    (ch_val[i]),
            .hit      (ch_hit[i])
        );
    end

    // Collect set events into flag positions.
    always_comb begin
        flag_set = '0;
        for (int i = 0; i < CH_NUM; i++) flag_set[ch_bit(i)] = ch_hit[i] || ch_cap[i];
        flag_set[OVF_BIT] = wrap;
    end

    // Clear mask from a flag-register write (ones clear).
    assign flag_clr = (wr_en && addr == A_FLAG) ? wdata[FLAG_W-1:0] : '0;

    // Sticky flags: a set in the same cycle overrides a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= ((flags_q & ~flag_clr) | flag_set) & FLAG_USED;
    end

    // Request lines.
    always_comb begin
        irq_cmp = 1'b0;
        for (int i = 0; i < LAST; i++) irq_cmp |= flags_q[ch_bit(i)] && mask_q[ch_bit(i)];
    end
    assign irq_ch4 = flags_q[ch_bit(LAST)] && mask_q[ch_bit(LAST)];
    assign irq_ovf = flags_q[OVF_BIT] && mask_q[OVF_BIT];

    // Read multiplexer.
    always_comb begin
        rd_data = '0;
        case (addr)
            A_CTRL:  rd_data = CNT_W'(ctrl_q);
            A_FLAG:  rd_data = CNT_W'(flags_q);
            A_MASK:  rd_data = CNT_W'(mask_q);
            A_CNT:   rd_data = cnt_q;
            default: rd_data = ch_val[int'(addr) - A_CH0];
        endcase
    end
endmodule

// File: rtl/tmr_chan_ctrl_chk.sv
// Checker for tmr_chan_ctrl: temporal properties over the counter, the flags
// and the request lines. It is bound into every instance of the top.
module tmr_chan_ctrl_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             stop,
    input logic             tick,
    input logic [CNT_W-1:0] cnt,
    input logic [7:0]       flags,
    input logic [7:0]       mask,
    input logic             cap_mode,
    input logic             cap_rise,
    input logic [CNT_W-1:0] ch4_val,
    input logic             irq_cmp
);
    // R1
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> (cnt == '0));

    // R1
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stop && !tick) |=> (cnt == $past(cnt)));

    // R4
    wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (&cnt)) |=> flags[3]);

    // R5
    cap_no_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_mode && !cap_rise && !flags[4]) |=> !flags[4]);

    // R6
    cap_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_mode && cap_rise) |=> (flags[4] && ch4_val == $past(cnt)));

    // R9
    cmp_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask[7:5] == 3'b000) |-> !irq_cmp);
endmodule

bind tmr_chan_ctrl tmr_chan_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .stop     (ctrl_q.stop),
    .tick     (tick),
    .cnt      (cnt_q),
    .flags    (flags_q),
    .mask     (mask_q),
    .cap_mode (ctrl_q.cap_mode),
    .cap_rise (cap_rise),
    .ch4_val  (ch_val[3]),
    .irq_cmp  (irq_cmp)
);

// File: tb/tmr_chan_ctrl_bench.sv
// Bench for tmr_chan_ctrl: sweeps divide factors and channels, and checks
// capture, flag clearing, masking and wrap against counts computed here.
module tmr_chan_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [15:0] wdata = 16'd0;
    logic [15:0] rd_data;
    logic        cap_in = 1'b0;
    logic        irq_cmp, irq_ch4, irq_ovf;
    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    tmr_chan_ctrl u_tmr_chan_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rd_data(rd_data), .cap_in(cap_in), .irq_cmp(irq_cmp),
        .irq_ch4(irq_ch4), .irq_ovf(irq_ovf)
    );

    localparam logic [2:0] CTRL = 3'd0, FLAG = 3'd1, MASK = 3'd2, CNT = 3'd3;

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int v);
        addr = a;
        #1;
        v = int'(rd_data);
    endtask

    task automatic halt_clear();
        wr(CTRL, 16'h0001);
        wr(FLAG, 16'h00F8);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R8 R11 reset state
        rd(CTRL, v); check("R11 ctrl reset", v, 0);
        rd(FLAG, v); check("R8 flag reset", v, 0);
        rd(MASK, v); check("R8 mask reset", v, 0);
        check("R10 irqs at reset", {irq_cmp, irq_ch4, irq_ovf}, 0);

        halt_clear();
        for (int c = 0; c < 4; c++) wr(3'(4 + c), 16'hF000);
        repeat (5) @(negedge clk);
        rd(CNT, v); check("R1 counter held while stopped", v, 0);

        // R2 R3 R9 sweep of divide factors and compare channels
        for (int s = 0; s < 4; s++) begin
            for (int ch = 0; ch < 3; ch++) begin
                int d, c, n;
                d = (s == 0) ? 1 : (1 << (s + 1));
                c = 2 + ch + s;
                n = (c + 1) * d;
                halt_clear();
                wr(3'(4 + ch), 16'(c));
                wr(MASK, 16'(1 << (7 - ch)));
                wr(CTRL, 16'(s << 2));
                repeat (n - 1) @(negedge clk);
                rd(FLAG, v); check("R3 flag not early", v, 0);
                check("R9 irq_cmp not early", int'(irq_cmp), 0);
                rd(CNT, v); check("R2 counter = floor(n/d)", v, c);
                @(negedge clk);
                rd(FLAG, v); check("R3 flag on match tick", v, 1 << (7 - ch));
                check("R9 irq_cmp on match", int'(irq_cmp), 1);
                wr(3'(4 + ch), 16'hF000);
            end
        end
        wr(MASK, 16'h0000);
        check("R9 masked compare no request", int'(irq_cmp), 0);

        // R7 clear by ones (channel three flag, bit 5, is set now)
        wr(FLAG, 16'h0000); rd(FLAG, v); check("R7 zero write keeps flag", v, 8'h20);
        wr(FLAG, 16'h0040); rd(FLAG, v); check("R7 other bit keeps flag", v, 8'h20);
        wr(FLAG, 16'h0020); rd(FLAG, v); check("R7 one clears flag", v, 0);

        // R7 set wins over a same-cycle clear
        halt_clear();
        wr(4, 16'd4);
        wr(CTRL, 16'h0000);
        repeat (4) @(negedge clk);
        wr_en = 1'b1; addr = FLAG; wdata = 16'h0080;
        @(negedge clk);
        wr_en = 1'b0;
        rd(FLAG, v); check("R7 set beats clear", v & 8'h80, 8'h80);
        wr(4, 16'hF000);

        // R5 R10 channel four in compare mode
        halt_clear();
        wr(7, 16'd3);
        wr(MASK, 16'h0010);
        wr(CTRL, 16'h0000);
        repeat (4) @(negedge clk);
        rd(FLAG, v); check("R5 ch4 compare flag", v, 8'h10);
        check("R10 irq_ch4 compare", int'(irq_ch4), 1);

        // R5 capture mode ignores the compare match
        halt_clear();
        wr(CTRL, 16'h0003);
        wr(CTRL, 16'h0002);
        repeat (10) @(negedge clk);
        rd(FLAG, v); check("R5 capture mode blocks compare", v, 0);
        check("R10 irq_ch4 quiet", int'(irq_ch4), 0);

        // R6 capture timing and value
        halt_clear();
        wr(CTRL, 16'h0003);
        wr(CTRL, 16'h0002);
        repeat (10) @(negedge clk);
        cap_in = 1'b1;
        repeat (2) @(negedge clk);
        rd(FLAG, v); check("R6 no capture before sync", v, 0);
        @(negedge clk);
        rd(FLAG, v); check("R6 capture flag", v, 8'h10);
        rd(7, v);    check("R6 captured count", v, 12);
        check("R10 irq_ch4 capture", int'(irq_ch4), 1);
        cap_in = 1'b0;

        // R5 compare mode ignores capture edges
        halt_clear();
        wr(7, 16'hF000);
        wr(CTRL, 16'h0000);
        cap_in = 1'b1;
        repeat (5) @(negedge clk);
        cap_in = 1'b0;
        repeat (6) @(negedge clk);
        rd(7, v);    check("R5 compare mode no capture value", v, 16'hF000);
        rd(FLAG, v); check("R5 compare mode no capture flag", v & 8'h10, 0);

        // R4 wrap
        halt_clear();
        wr(MASK, 16'h0008);
        wr(CTRL, 16'h0000);
        repeat (65535) @(negedge clk);
        rd(FLAG, v); check("R4 no wrap flag early", v & 8'h08, 0);
        check("R10 irq_ovf early", int'(irq_ovf), 0);
        @(negedge clk);
        rd(FLAG, v); check("R4 wrap flag", v & 8'h08, 8'h08);
        rd(CNT, v);  check("R4 counter rolled to zero", v, 0);
        check("R10 irq_ovf on wrap", int'(irq_ovf), 1);

        // R8 unused enable bits
        wr(MASK, 16'h00FF);
        rd(MASK, v); check("R8 low enable bits read zero", v, 8'hF8);

        // R1 stop resets a running counter
        repeat (20) @(negedge clk);
        wr(CTRL, 16'h0001);
        @(negedge clk);
        rd(CNT, v); check("R1 stop zeroes counter", v, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule